// File: doc/BRIEF.md
# Programmable Periodic Rate Divider

This block turns a 32.768 kHz time base into a selectable periodic event. The time base arrives as a one-cycle enable on a fast system clock. A ripple of fifteen binary stages, built as groups of three, six and six, counts the enabled cycles. A 4-bit rate code chooses one of thirteen stage outputs as the active tap. Two outputs come from that tap. The first is a one-clock pulse on each rising edge of the tap, which feeds a periodic interrupt flag. The second is a square wave with a 50% duty cycle, which can be switched off. The final stage also gives a once-per-second strobe to the timekeeping update, whatever the rate code.

The square wave is produced by a three-state machine. `ST_MUTE` drives the output low. `ST_LOW` and `ST_HIGH` track the selected tap. The machine goes from any state to `ST_MUTE` when the gate closes. The gate closes when the rate code is 0, when the enable input is low, or when power-fail is high. When the gate opens, the machine leaves `ST_MUTE` for `ST_HIGH` or `ST_LOW`, according to the tap. It moves from `ST_LOW` to `ST_HIGH` when the tap rises, and from `ST_HIGH` to `ST_LOW` when the tap falls.

Top module: `periodic_rate_div`

## Requirements
- R1: While `rst_n` is low, all three outputs are low and the divider is cleared. After release with rate code 3 and one step per clock, the first `per_tick` is visible in the cycle after the second step.
- R2: The divider advances by one on each clock where `tick_en` and `osc_run` are both high, and it holds otherwise. Steps on alternate clocks therefore double the output period in clocks.
- R3: The period of the selected tap, in divider steps, is 128 for code 1 and 256 for code 2. It is 4 for code 3 and 2^(code-1) for codes 4 to 15. This runs from 8192 Hz down to 2 Hz.
- R4: `per_tick` is high for exactly one clock per selected period. It rises in the clock after the step that raises the tap.
- R5: With the gate open, `sq_out` is high for half of every period. It follows the tap one clock later.
- R6: Rate code 0 produces no `per_tick` pulse and keeps `sq_out` low.
- R7: With `sq_en` low, `sq_out` stays low and `per_tick` keeps pulsing at the selected rate.
- R8: With `pwr_fail` high, `sq_out` stays low and `per_tick` keeps pulsing at the selected rate.
- R9: `sec_strobe` pulses for one clock every 32768 divider steps, counted from reset, whatever the rate code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 32.768 kHz time-base enable, one clock wide |
| osc_run | input | 1 | Oscillator run; when low the divider holds |
| rate_sel | input | 4 | Rate code choosing the tap |
| sq_en | input | 1 | Square-wave enable |
| pwr_fail | input | 1 | Supply below the power-fail threshold |
| sq_out | output | 1 | Gated square wave |
| per_tick | output | 1 | One-clock pulse per selected period |
| sec_strobe | output | 1 | One-clock pulse per second of time base |

## Verification
The bench builds the block with its default stage groups of 3, 6 and 6. It holds `tick_en` high on almost every clock, so each clock is one divider step. This brings the slowest tap (2 Hz, 16384 steps) and the one-second wrap within tens of thousands of clocks. It can therefore measure all fifteen rate periods and their duty cycles exactly. It can also watch several one-second strobes while the rate code keeps changing.

// File: rtl/rate_div_pkg.sv
package rate_div_pkg;

    localparam int RATE_W = 4;

    typedef enum logic [1:0] {
        ST_MUTE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } wave_state_e;

    // Stage index of the tap chosen by a rate code (code 0 has no tap).
    function automatic logic [3:0] tap_index(input logic [RATE_W-1:0] code);
        logic [3:0] idx;
        case (code)
            4'd0:    idx = 4'd0;
            4'd1:    idx = 4'd6;
            4'd2:    idx = 4'd7;
            default: idx = code - 4'd2;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/rate_prescaler.sv
module rate_prescaler #(
    parameter int GRP_A = 3,
    parameter int GRP_B = 6,
    parameter int GRP_C = 6,
    localparam int STAGES = GRP_A + GRP_B + GRP_C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [STAGES-1:0] cnt,
    output logic [STAGES:0]   carry
);

    assign carry[0] = 1'b1;

    // One toggle stage per binary division; each toggles when all lower stages are high.
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= 1'b0;
            else if (step && carry[i])
                q <= ~q;
        end
        assign cnt[i]     = q;
        assign carry[i+1] = carry[i] & q;
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt));

    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !carry[STAGES]) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/rate_tap_mux.sv
module rate_tap_mux
    import rate_div_pkg::*;
#(
    parameter int STAGES = 15
) (
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [STAGES-1:0] cnt,
    input  logic [STAGES:0]   carry,
    output logic              tap_bit,
    output logic              tap_rise_ok,
    output logic              tap_valid
);

    logic [3:0] idx;

    always_comb begin
        idx         = tap_index(rate_sel);
        tap_valid   = (rate_sel != '0);
        tap_bit     = tap_valid & cnt[idx];
        // The tap rises on the next step when all lower stages are high and it is low.
        tap_rise_ok = tap_valid & carry[idx] & ~cnt[idx];
    end

endmodule

// File: rtl/rate_wave_fsm.sv
module rate_wave_fsm
    import rate_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate_open,
    input  logic tap_bit,
    output logic sq_out
);

    wave_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_MUTE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MUTE: if (gate_open) state_d = tap_bit ? ST_HIGH : ST_LOW;
            ST_LOW: begin
                if (!gate_open)   state_d = ST_MUTE;
                else if (tap_bit) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (!gate_open)    state_d = ST_MUTE;
                else if (!tap_bit) state_d = ST_LOW;
            end
            default: state_d = ST_MUTE;
        endcase
    end

    always_comb begin
        sq_out = (state_q == ST_HIGH);
    end

    p_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |=> !sq_out);

    p_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open && tap_bit) |=> sq_out);

endmodule

// File: rtl/periodic_rate_div.sv
module periodic_rate_div
    import rate_div_pkg::*;
#(
    parameter int GRP_A = 3,
    parameter int GRP_B = 6,
    parameter int GRP_C = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              osc_run,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              sq_en,
    input  logic              pwr_fail,
    output logic              sq_out,
    output logic              per_tick,
    output logic              sec_strobe
);

    localparam int STAGES = GRP_A + GRP_B + GRP_C;

    logic              step;
    logic [STAGES-1:0] cnt;
    logic [STAGES:0]   carry;
    logic              tap_bit, tap_rise_ok, tap_valid;
    logic              gate_open;
    logic              tick_q, sec_q;

    assign step      = tick_en & osc_run;
    assign gate_open = tap_valid & sq_en & ~pwr_fail;

    rate_prescaler #(.GRP_A(GRP_A), .GRP_B(GRP_B), .GRP_C(GRP_C)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .cnt   (cnt),
        .carry (carry)
    );

    rate_tap_mux #(.STAGES(STAGES)) u_mux (
        .rate_sel    (rate_sel),
        .cnt         (cnt),
        .carry       (carry),
        .tap_bit     (tap_bit),
        .tap_rise_ok (tap_rise_ok),
        .tap_valid   (tap_valid)
    );

    rate_wave_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_open (gate_open),
        .tap_bit   (tap_bit),
        .sq_out    (sq_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
            sec_q  <= 1'b0;
        end else begin
            tick_q <= step & tap_rise_ok;
            sec_q  <= step & carry[STAGES];
        end
    end

    assign per_tick   = tick_q;
    assign sec_strobe = sec_q;

    p_rate0_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0) |=> (!per_tick && !sq_out));

    p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        per_tick |=> !per_tick);

    p_pf_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> !sq_out);

    p_strobe_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sec_strobe |-> (cnt == '0));

endmodule

// File: tb/test_periodic_rate_div.sv
`timescale 1ns/1ps
module test_periodic_rate_div;

    logic       clk = 1'b0;
    logic       rst_n, tick_en, osc_run, sq_en, pwr_fail;
    logic [3:0] rate_sel;
    logic       sq_out, per_tick, sec_strobe;

    always #10 clk = ~clk;

    periodic_rate_div i_periodic_rate_div (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .osc_run(osc_run),
        .rate_sel(rate_sel), .sq_en(sq_en), .pwr_fail(pwr_fail),
        .sq_out(sq_out), .per_tick(per_tick), .sec_strobe(sec_strobe)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Bench-side count of divider steps it has driven.
    int steps = 0;
    always @(posedge clk) begin
        if (!rst_n) steps <= 0;
        else if (tick_en && osc_run) steps <= steps + 1;
    end

    // R9 monitor: strobe spacing in steps.
    int n_strobe = 0;
    int last_strobe = 0;
    always @(negedge clk) begin
        if (rst_n && sec_strobe) begin
            n_strobe++;
            chk(steps - last_strobe == 32768, "R9", "steps between strobes",
                steps - last_strobe, 32768);
            last_strobe = steps;
        end
    end

    // Scoreboard: the driver pushes expected periods, the monitor measures them.
    int exp_q[$];
    bit armed = 0;
    initial begin
        bit started = 0;
        int n = 0;
        int hi = 0;
        forever begin
            @(negedge clk);
            if (armed) begin
                if (per_tick) begin
                    if (started) begin
                        int e;
                        e = exp_q.pop_front();
                        chk(n == e, "R3", "period in clocks", n, e);
                        chk(hi == e / 2, "R5", "square-wave high clocks", hi, e / 2);
                        started = 0;
                        armed   = 0;
                    end else begin
                        started = 1;
                        n  = 1;
                        hi = int'(sq_out);
                    end
                end else if (started) begin
                    n++;
                    hi += int'(sq_out);
                end
            end
        end
    end

    task automatic run_rate(input logic [3:0] code, input int period);
        @(negedge clk);
        rate_sel = code;
        repeat (2) @(negedge clk);
        exp_q.push_back(period);
        armed = 1;
        while (armed) @(negedge clk);
    endtask

    task automatic window(input int len, output int pulses, output int highs);
        pulses = 0;
        highs  = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            pulses += int'(per_tick);
            highs  += int'(sq_out);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_up();
        end
    end

    initial begin
        int p, h;
        rst_n = 0; tick_en = 1; osc_run = 1; sq_en = 1; pwr_fail = 0; rate_sel = 4'd3;
        repeat (5) @(negedge clk);
        chk(!sq_out, "R1", "sq_out in reset", sq_out, 0);
        chk(!per_tick, "R1", "per_tick in reset", per_tick, 0);
        chk(!sec_strobe, "R1", "sec_strobe in reset", sec_strobe, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!per_tick, "R1", "per_tick after first step", per_tick, 0);
        @(negedge clk);
        chk(per_tick, "R1", "per_tick after second step", per_tick, 1);

        // R4: code 4 gives period 8, so 80 clocks hold 10 one-clock pulses.
        rate_sel = 4'd4;
        repeat (2) @(negedge clk);
        window(80, p, h);
        chk(p == 10, "R4", "pulse clocks in 80", p, 10);

        // R3 and R5 over every code.
        for (int c = 1; c < 16; c++) begin
            int per;
            per = (c == 1) ? 128 : (c == 2) ? 256 : (c == 3) ? 4 : (1 << (c - 1));
            run_rate(4'(c), per);
        end

        // R6: code 0 is silent.
        rate_sel = 4'd0;
        repeat (2) @(negedge clk);
        window(300, p, h);
        chk(p == 0, "R6", "pulses with code 0", p, 0);
        chk(h == 0, "R6", "sq high with code 0", h, 0);

        // R7: square wave off, ticks continue.
        rate_sel = 4'd3; sq_en = 0;
        repeat (2) @(negedge clk);
        window(40, p, h);
        chk(p == 10, "R7", "pulses with sq_en low", p, 10);
        chk(h == 0, "R7", "sq high with sq_en low", h, 0);

        // R8: power-fail gates the square wave only.
        sq_en = 1; pwr_fail = 1;
        repeat (2) @(negedge clk);
        window(40, p, h);
        chk(p == 10, "R8", "pulses with pwr_fail", p, 10);
        chk(h == 0, "R8", "sq high with pwr_fail", h, 0);
        pwr_fail = 0;
        repeat (2) @(negedge clk);
        window(40, p, h);
        chk(h == 20, "R5", "sq high after pwr_fail clears", h, 20);

        // R2: oscillator stopped holds; resume steps; alternate steps halve rate.
        osc_run = 0;
        repeat (2) @(negedge clk);
        window(50, p, h);
        chk(p == 0, "R2", "pulses while held", p, 0);
        osc_run = 1;
        window(4, p, h);
        chk(p == 1, "R2", "pulses in 4 after resume", p, 1);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            tick_en = ~tick_en;
            p += 0;
        end
        tick_en = 1;
        begin
            int cntp = 0;
            for (int i = 0; i < 80; i++) begin
                @(negedge clk);
                tick_en = (i % 2 == 0);
                cntp += int'(per_tick);
            end
            tick_en = 1;
            chk(cntp == 10, "R2", "pulses in 80 with alternate steps", cntp, 10);
        end

        // R9: at least two strobes while rates changed.
        rate_sel = 4'd15;
        while (n_strobe < 2) @(negedge clk);
        chk(n_strobe >= 2, "R9", "strobes seen", n_strobe, 2);

        done = 1;
        finish_up();
    end

endmodule